// File: doc/BRIEF.md
# Display Identification Memory Streaming Front End

This block is the front end of a 128-byte serial configuration memory that a display uses to identify itself. Out of reset it runs in a transmit-only mode. An external stream clock is sampled with the system clock. On each of its rising edges the block sends the next bit of the memory contents on a shared open-drain data line. Synchronization takes nine stream-clock cycles. After that, each byte goes out most significant bit first, followed by a released ninth bit. Addresses run upward and wrap from the last location back to the first.

A qualified falling edge on the bidirectional bus clock switches the block permanently into bidirectional mode. In that mode the stream clock no longer moves data. Its high level only qualifies writes. The memory array itself sits outside the block and is reached through a synchronous read port: the data for an address appears one system clock after that address is presented. The full bidirectional protocol engine is not part of this block.

Top module: `id_stream_eeprom`

## Requirements
- R1: While reset is asserted and just after it is released, `biMode` is 0, `sdaDriveLow` is 0 (line released) and `writeAllow` is 0.
- R2: For the first 9 rising edges of `streamClk` after reset, `sdaDriveLow` stays 0.
- R3: From the 10th rising edge of `streamClk` on, each rising edge presents one data bit. A data bit of 0 sets `sdaDriveLow` to 1 and a data bit of 1 sets it to 0. The bits of each byte go out with bit 7 first and bit 0 last.
- R4: The 9th rising edge of every byte slot is a null bit, which sets `sdaDriveLow` to 0.
- R5: Successive bytes come from successive addresses on `memAddr`, wrapping from 127 to 0. The first byte comes from the address `START_ADDR`, which the stream consumer must treat as unknown.
- R6: A falling edge of `busClk`, after it has been high for at least `HIGH_MIN` (2) synchronized system clocks, sets `biMode` to 1 within 4 system clocks.
- R7: A high pulse on `busClk` shorter than `HIGH_MIN` synchronized clocks is ignored when it falls: `biMode` stays 0.
- R8: While `biMode` is 1, `sdaDriveLow` is 0 and rising edges of `streamClk` do not change it.
- R9: `writeAllow` is 1 exactly when `biMode` is 1 and the synchronized `streamClk` is high.
- R10: Once `biMode` is 1 it stays 1 whatever `busClk` and `streamClk` do, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset (power-up) |
| streamClk | input | 1 | Asynchronous stream clock for transmit-only mode |
| busClk | input | 1 | Asynchronous bidirectional bus clock |
| memAddr | output | 7 | Read address to the 128x8 array |
| memRdData | input | 8 | Array read data, valid one clock after `memAddr` |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| biMode | output | 1 | 1 once the block is in bidirectional mode |
| writeAllow | output | 1 | Write qualifier for the bidirectional engine |

## Verification
The checker assumes that each level of `streamClk` and `busClk` is held for several system clocks. Under that assumption, a stream-clock edge is fully synchronized before the next one arrives, and `busClk` is already low when the mode flips. The stimulus holds every level of both clocks for six system clocks. The only exception is the deliberate one-clock `busClk` pulse, which is placed between two falling clock edges so that exactly one rising edge samples it. The array model returns a distinct value for every address. This lets the bench find where the stream starts from the first received byte instead of assuming an address.

// File: rtl/id_stream_pkg.sv
package id_stream_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = $clog2(DATA_W);

  // strobes from control to datapath
  typedef struct packed {
    logic             sendBit;   // drive the selected bit
    logic [SEL_W-1:0] bitPos;    // bit index of the byte to drive
    logic             sendNull;  // release line for the null slot
    logic             nextAddr;  // step the byte address
    logic             toBus;     // mode switch: release the line
  } strobe_t;
endpackage

// File: rtl/id_stream_sync.sv
module id_stream_sync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  input  logic resetVal,
  output logic syncOut
);
  logic stage1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= resetVal;
      syncOut <= resetVal;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/id_stream_ctrl.sv
module id_stream_ctrl
  import id_stream_pkg::*;
#(
  parameter int PRE_CYCLES = 9,
  parameter int HIGH_MIN   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    streamClk,
  input  logic    busClk,
  output strobe_t strobe,
  output logic    biMode,
  output logic    writeAllow
);
  localparam int PRE_W = $clog2(PRE_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int HC_W  = $clog2(HIGH_MIN + 1);

  logic vSync, sSync, vPrev;
  logic [PRE_W-1:0] preCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [HC_W-1:0]  hiCnt;
  logic vRise, fallOk, aligned, tick;

  id_stream_sync u_vSync (.clk(clk), .rstN(rstN), .asyncIn(streamClk), .resetVal(1'b0), .syncOut(vSync));
  id_stream_sync u_sSync (.clk(clk), .rstN(rstN), .asyncIn(busClk),    .resetVal(1'b0), .syncOut(sSync));

  assign vRise   = vSync & ~vPrev;
  assign fallOk  = ~sSync & (hiCnt >= HC_W'(HIGH_MIN)) & ~biMode;
  assign aligned = (preCnt == PRE_W'(PRE_CYCLES));
  assign tick    = vRise & ~biMode & ~fallOk & aligned;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPrev  <= 1'b0;
      hiCnt  <= '0;
      preCnt <= '0;
      bitIdx <= '0;
      biMode <= 1'b0;
    end else begin
      vPrev <= vSync;
      if (!sSync) hiCnt <= '0;
      else if (hiCnt < HC_W'(HIGH_MIN)) hiCnt <= hiCnt + 1'b1;
      if (fallOk) biMode <= 1'b1;
      if (vRise && !biMode && !fallOk) begin
        if (!aligned) preCnt <= preCnt + 1'b1;
        else if (bitIdx == BIT_W'(DATA_W)) bitIdx <= '0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.sendBit  = tick & (bitIdx < BIT_W'(DATA_W));
    strobe.bitPos   = SEL_W'(DATA_W - 1) - bitIdx[SEL_W-1:0];
    strobe.sendNull = tick & (bitIdx == BIT_W'(DATA_W));
    strobe.nextAddr = tick & (bitIdx == BIT_W'(DATA_W));
    strobe.toBus    = fallOk;
  end

  assign writeAllow = biMode & vSync;
endmodule

// File: rtl/id_stream_dp.sv
module id_stream_dp
  import id_stream_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sdaDriveLow
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr     <= START_ADDR;
      sdaDriveLow <= 1'b0;
    end else begin
      if (strobe.toBus || strobe.sendNull) sdaDriveLow <= 1'b0;
      else if (strobe.sendBit) sdaDriveLow <= ~memRdData[strobe.bitPos];
      if (strobe.nextAddr) memAddr <= memAddr + 1'b1;
    end
  end
endmodule

// File: rtl/id_stream_eeprom.sv
module id_stream_eeprom
  import id_stream_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int PRE_CYCLES = 9,
  parameter int HIGH_MIN   = 2,
  parameter logic [ADDR_W-1:0] START_ADDR = 7'd120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              streamClk,
  input  logic              busClk,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              sdaDriveLow,
  output logic              biMode,
  output logic              writeAllow
);
  strobe_t strobe;

  id_stream_ctrl #(.PRE_CYCLES(PRE_CYCLES), .HIGH_MIN(HIGH_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .streamClk(streamClk), .busClk(busClk),
    .strobe(strobe), .biMode(biMode), .writeAllow(writeAllow)
  );

  id_stream_dp #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .memAddr(memAddr), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: rtl/id_stream_chk.sv
module id_stream_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busClk,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sdaDriveLow,
  input logic              biMode,
  input logic              writeAllow
);
  // R10: the mode never falls back without reset
  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (!rstN)
    biMode |=> biMode);

  // R8: line released in bidirectional mode
  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    biMode |-> !sdaDriveLow);

  // R9: write qualifier only in bidirectional mode
  a_r9_write_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    writeAllow |-> biMode);

  // R5: address only steps by one, with wrap
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr != $past(memAddr)) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  // R6: mode entry only while the bus clock is low
  a_r6_enter_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biMode) |-> !busClk);
endmodule

bind id_stream_eeprom id_stream_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busClk(busClk), .memAddr(memAddr),
  .sdaDriveLow(sdaDriveLow), .biMode(biMode), .writeAllow(writeAllow)
);

// File: tb/id_stream_eeprom_tb.sv
module id_stream_eeprom_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic streamClk = 1'b0;
  logic busClk = 1'b0;
  logic [6:0] memAddr;
  logic [7:0] memRdData;
  logic sdaDriveLow, biMode, writeAllow;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  id_stream_eeprom u_dut (
    .clk(clk), .rstN(rstN), .streamClk(streamClk), .busClk(busClk),
    .memAddr(memAddr), .memRdData(memRdData), .sdaDriveLow(sdaDriveLow),
    .biMode(biMode), .writeAllow(writeAllow)
  );

  function automatic logic [7:0] content(input logic [6:0] a);
    return 8'(a * 37 + 5);
  endfunction

  always_ff @(posedge clk) memRdData <= content(memAddr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one stream-clock cycle; returns sdaDriveLow seen after the rise
  task automatic vPulse(output logic low);
    streamClk = 1'b1;
    waitClk(6);
    low = sdaDriveLow;
    streamClk = 1'b0;
    waitClk(6);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    streamClk = 1'b0;
    busClk = 1'b0;
    waitClk(4);
    check("R1 mode in reset", biMode, 0);
    check("R1 line in reset", sdaDriveLow, 0);
    rstN = 1'b1;
    waitClk(3);
    check("R1 mode after reset", biMode, 0);
    check("R1 line after reset", sdaDriveLow, 0);
    check("R1 write after reset", writeAllow, 0);
  endtask

  task automatic testGlitch();
    busClk = 1'b1;
    @(negedge clk);
    busClk = 1'b0;
    waitClk(8);
    check("R7 short pulse ignored", biMode, 0);
    busClk = 1'b1;
    waitClk(8);
  endtask

  task automatic testPreamble();
    logic low;
    for (int i = 0; i < 9; i++) begin
      vPulse(low);
      check("R2 preamble released", low, 0);
    end
  endtask

  task automatic readByte(output logic [7:0] b, output logic nullLow);
    logic low;
    for (int i = 7; i >= 0; i--) begin
      vPulse(low);
      b[i] = ~low;
    end
    vPulse(nullLow);
  endtask

  task automatic testStream();
    logic [7:0] b;
    logic nl;
    logic [6:0] base;
    bit found;
    readByte(b, nl);
    check("R4 null bit byte 0", nl, 0);
    found = 1'b0;
    base = '0;
    for (int a = 0; a < 128; a++)
      if (content(7'(a)) == b && !found) begin
        base = 7'(a);
        found = 1'b1;
      end
    check("R3 first byte matches array", found, 1);
    for (int k = 1; k < 12; k++) begin
      readByte(b, nl);
      check("R5 R3 consecutive byte", b, content(7'(base + k)));
      check("R4 null bit", nl, 0);
    end
  endtask

  task automatic testBusMode();
    logic low;
    busClk = 1'b0;
    waitClk(6);
    check("R6 enters bidirectional", biMode, 1);
    check("R8 line released", sdaDriveLow, 0);
    for (int i = 0; i < 4; i++) begin
      vPulse(low);
      check("R8 stream clock ignored", low, 0);
    end
    streamClk = 1'b1;
    waitClk(6);
    check("R9 write with stream high", writeAllow, 1);
    streamClk = 1'b0;
    waitClk(6);
    check("R9 no write with stream low", writeAllow, 0);
    busClk = 1'b1;
    waitClk(8);
    busClk = 1'b0;
    waitClk(8);
    check("R10 mode kept", biMode, 1);
  endtask

  task automatic testReturn();
    logic low;
    doReset();
    check("R10 reset returns to transmit", biMode, 0);
    busClk = 1'b1;
    waitClk(4);
    vPulse(low);
    check("R2 preamble restarts", low, 0);
  endtask

  initial begin
    doReset();
    testGlitch();
    testPreamble();
    testStream();
    testBusMode();
    testReturn();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule